// File: doc/BRIEF.md
# Dual-Mode Auto-Reload Timer

This block is a 16-bit up-counter that works either as one 16-bit auto-reload timer or as two separate 8-bit auto-reload timers. An 8-bit control register selects the mode and holds both overflow flags. A small register port gives a CPU read and write access to the control byte, the two count bytes and the two reload bytes. Counting advances on single-cycle tick enables that other logic supplies: a system tick divided by 12, and two divide-by-8 ticks from an external source and a real-time source.

There is also a capture mode. In this mode each selected reference tick copies the live count into the reload register and sets the high flag. The counter keeps running and wraps to zero rather than reloading. A single interrupt line combines the high flag, the low flag and the low-byte enable, and is qualified by an interrupt-enable input. The tick dividers and the interrupt controller sit outside this block.

Top module: `dual_reload_timer`

## Requirements
- R1: After reset, every mapped register reads 0x00 and `irq` is low.
- R2: Register addresses are 0 for control, 1 for count low, 2 for count high, 3 for reload low and 4 for reload high. Every mapped register reads back what was written to it. The control bits, from bit 7 down to bit 0, are: high flag, low flag, low interrupt enable, capture enable, split, run, source select and alternate clock. Addresses 5 to 7 read 0x00, and writes to them change nothing.
- R3: With split = 0 and run = 1, each count tick adds one to the 16-bit count. A tick at 0xFFFF loads the 16-bit reload value and sets both flags. A tick that takes the low byte from 0xFF to 0x00 at any other count sets only the low flag.
- R4: With split = 1, the low byte counts on every tick whatever the value of run. At 0xFF it loads the reload low byte and sets the low flag. The high byte counts only while run = 1. At 0xFF it loads the reload high byte and sets the high flag.
- R5: With split = 0 and run = 0, the count does not change.
- R6: With alternate clock = 0, the count tick is `tick_sys12`. With alternate clock = 1, the count tick is `tick_ext8` when source select = 0 and `tick_rtc8` when source select = 1.
- R7: With capture enable = 1, the trigger is `tick_rtc8` when source select = 0 and `tick_ext8` when source select = 1. Each trigger copies the 16-bit count into the reload register and sets the high flag. While capture is enabled, a counter that overflows wraps to zero and does not reload.
- R8: The hardware only ever sets the flags. A write to the control register replaces the whole register and takes precedence over any flag set in the same cycle.
- R9: `irq` is high exactly when `irq_en` = 1 and either the high flag is set, or the low flag and the low interrupt enable are both set.
- R10: A write to a count byte takes precedence over counting for that byte in the same cycle. A write to a reload byte takes precedence over a capture for that byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_wr | input | 1 | Write strobe for the register port |
| bus_addr | input | 3 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for `bus_addr` (combinational) |
| tick_sys12 | input | 1 | System clock / 12 enable |
| tick_ext8 | input | 1 | External source / 8 enable |
| tick_rtc8 | input | 1 | Real-time source / 8 enable |
| irq_en | input | 1 | Timer interrupt enable |
| irq | output | 1 | Combined interrupt request |

## Verification
Some behaviours hold on every cycle, so properties check them continuously. These are the stickiness of both flags, the gating of `irq` by `irq_en` and by the high flag, the frozen count in 16-bit mode when the timer is stopped, free running of the low byte in split mode, and the capture copy that follows an RTC trigger. Other behaviours only show up in the bench's scenarios. These are reload values at both overflow widths, the choice of tick and trigger source, write-versus-event precedence, and the wrap to zero in capture mode. The bench drives these from directed cases and a long seeded random run, and compares them against a behavioural model.

// File: rtl/timer_pkg.sv
// Shared types and register map for the dual-mode auto-reload timer.
// Assumes an 8-bit control register and byte-wide register access.
package timer_pkg;
    localparam int CTRL_W   = 8;
    localparam int A_CTRL   = 0;
    localparam int A_CNT_LO = 1;  // count byte gi sits at A_CNT_LO + gi
    localparam int A_RLD_LO = 3;  // reload byte gi sits at A_RLD_LO + gi
    localparam int NBYTES   = 2;

    typedef struct packed {
        logic ovf_hi;
        logic ovf_lo;
        logic lo_ie;
        logic cap_en;
        logic split;
        logic run;
        logic src_sel;
        logic alt_clk;
    } ctrl_t;
endpackage

// File: rtl/tmr_tick_mux.sv
// Selects the count tick and the capture trigger from the three tick
// enables. Assumes all ticks are single-cycle, bus-clock synchronous.
module tmr_tick_mux (
    input  logic alt_clk,
    input  logic src_sel,
    input  logic cap_en,
    input  logic tick_sys12,
    input  logic tick_ext8,
    input  logic tick_rtc8,
    output logic cnt_tick,
    output logic cap_trig
);
    // Count source: the system tick, or one of the two slow ticks.
    always_comb begin
        if (alt_clk) cnt_tick = src_sel ? tick_rtc8 : tick_ext8;
        else         cnt_tick = tick_sys12;
    end

    // Capture source uses the opposite sense of the same select bit.
    always_comb begin
        cap_trig = cap_en & (src_sel ? tick_ext8 : tick_rtc8);
    end
endmodule

// File: rtl/tmr_byte_ctr.sv
// One counter slice with reload-or-zero on wrap and a direct write port.
// A write wins over an increment in the same cycle. The wrap output is
// raised whenever an increment hits the all-ones value, even if a write
// replaces the result.
module tmr_byte_ctr #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         inc,
    input  logic         load_on_wrap,
    input  logic [W-1:0] reload_val,
    input  logic         wr_en,
    input  logic [W-1:0] wr_data,
    output logic [W-1:0] value,
    output logic         at_max,
    output logic         wrap
);
    logic [W-1:0] val_q;

    assign at_max = (val_q == {W{1'b1}});
    assign wrap   = inc & at_max;
    assign value  = val_q;

    // Slice register: write, then increment with reload-or-zero on wrap.
    always_ff @(posedge clk) begin
        if (!rst_n)       val_q <= '0;
        else if (wr_en)   val_q <= wr_data;
        else if (inc) begin
            if (at_max)   val_q <= load_on_wrap ? reload_val : '0;
            else          val_q <= val_q + W'(1);
        end
    end
endmodule

// File: rtl/dual_reload_timer.sv
// Dual-mode auto-reload timer: one 16-bit counter, or two independent
// counters of BYTE_W bits each, with sticky overflow flags, capture mode
// and a combined interrupt. Requires BYTE_W >= 8 so that the control byte
// fits on the bus. Reads are combinational.
module dual_reload_timer
    import timer_pkg::*;
#(
    parameter int BYTE_W = 8,
    parameter int ADDR_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [BYTE_W-1:0] bus_wdata,
    output logic [BYTE_W-1:0] bus_rdata,
    input  logic              tick_sys12,
    input  logic              tick_ext8,
    input  logic              tick_rtc8,
    input  logic              irq_en,
    output logic              irq
);
    localparam int CNT_W = NBYTES * BYTE_W;

    ctrl_t              ctrl_q;
    logic [CNT_W-1:0]   cnt_q;
    logic [CNT_W-1:0]   rld_q;
    logic               cnt_tick;
    logic               cap_trig;
    logic               wr_ctrl;
    logic               b_inc  [NBYTES];
    logic               b_load [NBYTES];
    logic               b_max  [NBYTES];
    logic               b_wrap [NBYTES];
    logic [BYTE_W-1:0]  b_val  [NBYTES];
    logic [BYTE_W-1:0]  b_rld  [NBYTES];

    assign wr_ctrl = bus_wr && (bus_addr == ADDR_W'(A_CTRL));

    tmr_tick_mux u_mux (
        .alt_clk    (ctrl_q.alt_clk),
        .src_sel    (ctrl_q.src_sel),
        .cap_en     (ctrl_q.cap_en),
        .tick_sys12 (tick_sys12),
        .tick_ext8  (tick_ext8),
        .tick_rtc8  (tick_rtc8),
        .cnt_tick   (cnt_tick),
        .cap_trig   (cap_trig)
    );

    // Low slice: free-running in split mode, gated by run otherwise.
    assign b_inc[0]  = ctrl_q.split ? cnt_tick : (ctrl_q.run & cnt_tick);
    // High slice: own run-gated tick in split mode, carry in 16-bit mode.
    assign b_inc[1]  = ctrl_q.split ? (ctrl_q.run & cnt_tick) : b_wrap[0];
    // The low slice reloads only on a full-width wrap in 16-bit mode.
    assign b_load[0] = !ctrl_q.cap_en && (ctrl_q.split || b_max[1]);
    assign b_load[1] = !ctrl_q.cap_en;

    generate
        for (genvar gi = 0; gi < NBYTES; gi++) begin : g_byte
            logic wr_cnt;
            logic wr_rld;
            logic [BYTE_W-1:0] rld_r;

            assign wr_cnt = bus_wr && (bus_addr == ADDR_W'(A_CNT_LO + gi));
            assign wr_rld = bus_wr && (bus_addr == ADDR_W'(A_RLD_LO + gi));

            tmr_byte_ctr #(.W(BYTE_W)) u_ctr (
                .clk          (clk),
                .rst_n        (rst_n),
                .inc          (b_inc[gi]),
                .load_on_wrap (b_load[gi]),
                .reload_val   (rld_r),
                .wr_en        (wr_cnt),
                .wr_data      (bus_wdata),
                .value        (b_val[gi]),
                .at_max       (b_max[gi]),
                .wrap         (b_wrap[gi])
            );

            // Reload/capture byte: a software write wins over a capture.
            always_ff @(posedge clk) begin
                if (!rst_n)        rld_r <= '0;
                else if (wr_rld)   rld_r <= bus_wdata;
                else if (cap_trig) rld_r <= b_val[gi];
            end

            assign b_rld[gi] = rld_r;
            assign cnt_q[gi*BYTE_W +: BYTE_W] = b_val[gi];
            assign rld_q[gi*BYTE_W +: BYTE_W] = rld_r;
        end
    endgenerate

    // Control register: a write replaces everything, otherwise flags only set.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q <= '0;
        end else if (wr_ctrl) begin
            ctrl_q <= ctrl_t'(bus_wdata[CTRL_W-1:0]);
        end else begin
            if (b_wrap[1] || cap_trig) ctrl_q.ovf_hi <= 1'b1;
            if (b_wrap[0])             ctrl_q.ovf_lo <= 1'b1;
        end
    end

    // Combined interrupt request.
    always_comb begin
        irq = irq_en & (ctrl_q.ovf_hi | (ctrl_q.ovf_lo & ctrl_q.lo_ie));
    end

    // Read multiplexer; unmapped addresses return zero.
    always_comb begin
        case (int'(bus_addr))
            A_CTRL:       bus_rdata = BYTE_W'(ctrl_q);
            A_CNT_LO:     bus_rdata = b_val[0];
            A_CNT_LO + 1: bus_rdata = b_val[1];
            A_RLD_LO:     bus_rdata = b_rld[0];
            A_RLD_LO + 1: bus_rdata = b_rld[1];
            default:      bus_rdata = '0;
        endcase
    end
endmodule

// File: rtl/tmr_checker.sv
// Cycle-by-cycle properties of the dual-mode timer, bound into the top.
// Control bit indices: 7 high flag, 6 low flag, 4 capture, 3 split,
// 2 run, 1 source select, 0 alternate clock.
module tmr_checker #(
    parameter int BYTE_W = 8,
    parameter int ADDR_W = 3
) (
    input logic                clk,
    input logic                rst_n,
    input logic                bus_wr,
    input logic [ADDR_W-1:0]   bus_addr,
    input logic                tick_sys12,
    input logic                tick_rtc8,
    input logic                irq_en,
    input logic                irq,
    input logic [7:0]          ctrl_q,
    input logic [2*BYTE_W-1:0] cnt_q,
    input logic [2*BYTE_W-1:0] rld_q
);
    logic wr_c, wr_lo, wr_hi, wr_rl;
    assign wr_c  = bus_wr && (bus_addr == ADDR_W'(0));
    assign wr_lo = bus_wr && (bus_addr == ADDR_W'(1));
    assign wr_hi = bus_wr && (bus_addr == ADDR_W'(2));
    assign wr_rl = bus_wr && ((bus_addr == ADDR_W'(3)) || (bus_addr == ADDR_W'(4)));

    // R8: a set flag stays set until the control register is written.
    assert_flag_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_q[7] && !wr_c) |=> ctrl_q[7]);
    assert_lo_flag_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_q[6] && !wr_c) |=> ctrl_q[6]);

    // R9: no interrupt without the enable; a high flag always interrupts.
    assert_irq_gated_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !irq_en |-> !irq);
    assert_irq_hi_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_en && ctrl_q[7]) |-> irq);

    // R5: a stopped 16-bit counter holds its value.
    assert_hold_stopped_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!ctrl_q[3] && !ctrl_q[2] && !wr_lo && !wr_hi) |=> (cnt_q == $past(cnt_q)));

    // R4: in split mode the low byte counts with run off; the high byte holds.
    assert_lo_free_run_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_q[3] && !ctrl_q[2] && !ctrl_q[0] && tick_sys12 &&
         (cnt_q[BYTE_W-1:0] != {BYTE_W{1'b1}}) && !wr_lo && !wr_hi)
        |=> ((cnt_q[BYTE_W-1:0] == $past(cnt_q[BYTE_W-1:0]) + BYTE_W'(1)) &&
             (cnt_q[2*BYTE_W-1:BYTE_W] == $past(cnt_q[2*BYTE_W-1:BYTE_W]))));

    // R7: an RTC trigger with source select 0 captures the count and flags it.
    assert_capture_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_q[4] && !ctrl_q[1] && tick_rtc8 && !wr_rl && !wr_c)
        |=> ((rld_q == $past(cnt_q)) && ctrl_q[7]));
endmodule

bind dual_reload_timer tmr_checker #(.BYTE_W(BYTE_W), .ADDR_W(ADDR_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .bus_wr     (bus_wr),
    .bus_addr   (bus_addr),
    .tick_sys12 (tick_sys12),
    .tick_rtc8  (tick_rtc8),
    .irq_en     (irq_en),
    .irq        (irq),
    .ctrl_q     (ctrl_q),
    .cnt_q      (cnt_q),
    .rld_q      (rld_q)
);

// File: tb/dual_reload_timer_tb.sv
// Self-checking bench: directed corner cases and then a seeded random run.
// Every cycle is compared against a behavioural model written from the
// requirements.
module dual_reload_timer_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bus_wr = 1'b0;
    logic [2:0] bus_addr = 3'd0;
    logic [7:0] bus_wdata = 8'd0;
    logic [7:0] bus_rdata;
    logic       tick_sys12 = 1'b0, tick_ext8 = 1'b0, tick_rtc8 = 1'b0;
    logic       irq_en = 1'b0;
    logic       irq;

    int checks = 0;
    int errors = 0;
    bit chk_on = 1'b0;
    bit ended  = 1'b0;

    logic [7:0]  m_ctrl;
    logic [15:0] m_cnt, m_rld;

    always #5 clk = ~clk;

    dual_reload_timer u_dut (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .tick_sys12(tick_sys12),
        .tick_ext8(tick_ext8), .tick_rtc8(tick_rtc8), .irq_en(irq_en), .irq(irq)
    );

    // Behavioural model of one clock cycle.
    always @(posedge clk) begin : model
        logic tk, trig, shi, slo;
        logic [15:0] ncnt, nrld;
        logic [7:0]  nctrl;
        if (!rst_n) begin
            m_ctrl = 8'h00; m_cnt = 16'h0000; m_rld = 16'h0000;
        end else begin
            tk   = m_ctrl[0] ? (m_ctrl[1] ? tick_rtc8 : tick_ext8) : tick_sys12;
            trig = m_ctrl[4] && (m_ctrl[1] ? tick_ext8 : tick_rtc8);
            shi = 1'b0; slo = 1'b0; ncnt = m_cnt; nrld = m_rld;
            if (!m_ctrl[3]) begin
                if (m_ctrl[2] && tk) begin
                    if (m_cnt == 16'hFFFF) begin
                        ncnt = m_ctrl[4] ? 16'h0000 : m_rld; shi = 1'b1; slo = 1'b1;
                    end else begin
                        if (m_cnt[7:0] == 8'hFF) slo = 1'b1;
                        ncnt = m_cnt + 16'd1;
                    end
                end
            end else begin
                if (tk) begin
                    if (m_cnt[7:0] == 8'hFF) begin
                        ncnt[7:0] = m_ctrl[4] ? 8'h00 : m_rld[7:0]; slo = 1'b1;
                    end else ncnt[7:0] = m_cnt[7:0] + 8'd1;
                end
                if (m_ctrl[2] && tk) begin
                    if (m_cnt[15:8] == 8'hFF) begin
                        ncnt[15:8] = m_ctrl[4] ? 8'h00 : m_rld[15:8]; shi = 1'b1;
                    end else ncnt[15:8] = m_cnt[15:8] + 8'd1;
                end
            end
            if (trig) begin nrld = m_cnt; shi = 1'b1; end
            nctrl = m_ctrl | {shi, slo, 6'b0};
            if (bus_wr) begin
                case (bus_addr)
                    3'd0: nctrl = bus_wdata;
                    3'd1: ncnt[7:0]  = bus_wdata;
                    3'd2: ncnt[15:8] = bus_wdata;
                    3'd3: nrld[7:0]  = bus_wdata;
                    3'd4: nrld[15:8] = bus_wdata;
                    default: ;
                endcase
            end
            m_ctrl = nctrl; m_cnt = ncnt; m_rld = nrld;
        end
    end

    function automatic logic [7:0] exp_read(input logic [2:0] a);
        case (a)
            3'd0: return m_ctrl;
            3'd1: return m_cnt[7:0];
            3'd2: return m_cnt[15:8];
            3'd3: return m_rld[7:0];
            3'd4: return m_rld[15:8];
            default: return 8'h00;
        endcase
    endfunction

    function automatic logic exp_irq();
        return irq_en & (m_ctrl[7] | (m_ctrl[6] & m_ctrl[5]));
    endfunction

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h at %0t", req, act, exp, $time);
        end
    endtask

    // Model comparison every cycle, away from the active edge.
    always @(negedge clk) begin
        if (chk_on && rst_n) begin
            case (bus_addr)
                3'd0:       check("R8 ctrl vs model", 16'(bus_rdata), 16'(exp_read(bus_addr)));
                3'd1, 3'd2: check("R3 count vs model", 16'(bus_rdata), 16'(exp_read(bus_addr)));
                3'd3, 3'd4: check("R7 reload vs model", 16'(bus_rdata), 16'(exp_read(bus_addr)));
                default:    check("R2 unmapped vs model", 16'(bus_rdata), 16'h0000);
            endcase
            check("R9 irq vs model", 16'(irq), 16'(exp_irq()));
        end
    end

    task automatic drive(input logic w, input logic [2:0] a, input logic [7:0] d,
                         input logic s, input logic e, input logic r);
        @(negedge clk); #1;
        bus_wr = w; bus_addr = a; bus_wdata = d;
        tick_sys12 = s; tick_ext8 = e; tick_rtc8 = r;
        @(negedge clk); #1;
        bus_wr = 1'b0; tick_sys12 = 1'b0; tick_ext8 = 1'b0; tick_rtc8 = 1'b0;
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        drive(1'b1, a, d, 1'b0, 1'b0, 1'b0);
    endtask

    task automatic pulse(input logic s, input logic e, input logic r);
        drive(1'b0, 3'd0, 8'h00, s, e, r);
    endtask

    task automatic peek(input logic [2:0] a, output logic [7:0] v);
        bus_addr = a; #1; v = bus_rdata;
    endtask

    task automatic peek16(input logic [2:0] a, output logic [15:0] v);
        logic [7:0] lo, hi;
        peek(a, lo); peek(a + 3'd1, hi); v = {hi, lo};
    endtask

    task automatic finish_run();
        if (!ended) begin
            ended = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        logic [7:0]  v;
        logic [15:0] v16;
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        #1 rst_n = 1'b1;
        chk_on = 1'b1;

        // R1: reset state
        for (int a = 0; a < 5; a++) begin
            peek(3'(a), v); check("R1 reset register", 16'(v), 16'h0000);
        end
        irq_en = 1'b1; #1;
        check("R1 irq after reset", 16'(irq), 16'h0000);

        // R2: read-back and unmapped addresses
        wr(3'd3, 8'hFE); wr(3'd4, 8'hFF); wr(3'd1, 8'hFF); wr(3'd2, 8'hFF);
        peek16(3'd3, v16); check("R2 reload read-back", v16, 16'hFFFE);
        wr(3'd6, 8'hFF);
        peek(3'd6, v); check("R2 unmapped reads zero", 16'(v), 16'h0000);
        peek(3'd0, v); check("R2 unmapped write ignored", 16'(v), 16'h0000);

        // R3: 16-bit overflow reloads and sets both flags
        wr(3'd0, 8'h04);
        pulse(1'b1, 1'b0, 1'b0);
        peek16(3'd1, v16); check("R3 full wrap reloads", v16, 16'hFFFE);
        peek(3'd0, v); check("R3 both flags", 16'(v), 16'h00C4);
        // R3: inner low-byte wrap sets only the low flag
        wr(3'd0, 8'h04); wr(3'd1, 8'hFF); wr(3'd2, 8'h10);
        pulse(1'b1, 1'b0, 1'b0);
        peek16(3'd1, v16); check("R3 carry into high", v16, 16'h1100);
        peek(3'd0, v); check("R3 low flag only", 16'(v), 16'h0044);

        // R5: stopped 16-bit counter holds
        wr(3'd0, 8'h00);
        pulse(1'b1, 1'b0, 1'b0); pulse(1'b1, 1'b0, 1'b0);
        peek16(3'd1, v16); check("R5 stopped count holds", v16, 16'h1100);

        // R4: split mode, low byte runs without run, reloads its own byte
        wr(3'd0, 8'h08); wr(3'd1, 8'hFF); wr(3'd2, 8'h20);
        wr(3'd3, 8'h30); wr(3'd4, 8'h55);
        pulse(1'b1, 1'b0, 1'b0);
        peek16(3'd1, v16); check("R4 low reload, high idle", v16, 16'h2030);
        peek(3'd0, v); check("R4 low flag", 16'(v), 16'h0048);
        wr(3'd0, 8'h0C); wr(3'd2, 8'hFF);
        pulse(1'b1, 1'b0, 1'b0);
        peek16(3'd1, v16); check("R4 high reload", v16, 16'h5531);
        peek(3'd0, v); check("R4 high flag", 16'(v), 16'h008C);

        // R6: tick source selection
        wr(3'd0, 8'h05); wr(3'd1, 8'h00); wr(3'd2, 8'h00);
        pulse(1'b1, 1'b0, 1'b1);
        peek16(3'd1, v16); check("R6 ext source ignores others", v16, 16'h0000);
        pulse(1'b0, 1'b1, 1'b0);
        peek16(3'd1, v16); check("R6 ext source counts", v16, 16'h0001);
        wr(3'd0, 8'h07);
        pulse(1'b0, 1'b1, 1'b0);
        peek16(3'd1, v16); check("R6 rtc source ignores ext", v16, 16'h0001);
        pulse(1'b0, 1'b0, 1'b1);
        peek16(3'd1, v16); check("R6 rtc source counts", v16, 16'h0002);

        // R7: capture
        wr(3'd0, 8'h10); wr(3'd1, 8'h34); wr(3'd2, 8'h12);
        pulse(1'b0, 1'b0, 1'b1);
        peek16(3'd3, v16); check("R7 rtc capture", v16, 16'h1234);
        peek(3'd0, v); check("R7 capture flag", 16'(v), 16'h0090);
        wr(3'd1, 8'h21); wr(3'd2, 8'h43);
        pulse(1'b0, 1'b1, 1'b0);
        peek16(3'd3, v16); check("R7 ext ignored as trigger", v16, 16'h1234);
        wr(3'd0, 8'h14); wr(3'd1, 8'hFF); wr(3'd2, 8'hFF);
        pulse(1'b1, 1'b0, 1'b0);
        peek16(3'd1, v16); check("R7 wrap to zero", v16, 16'h0000);
        peek(3'd0, v); check("R7 flags on wrap", 16'(v), 16'h00D4);
        wr(3'd0, 8'h12); wr(3'd1, 8'hBC); wr(3'd2, 8'h0A);
        pulse(1'b0, 1'b1, 1'b0);
        peek16(3'd3, v16); check("R7 ext capture", v16, 16'h0ABC);

        // R8: write wins over same-cycle flag set; flags persist
        wr(3'd0, 8'h04); wr(3'd3, 8'h02); wr(3'd4, 8'h01);
        wr(3'd1, 8'hFF); wr(3'd2, 8'hFF);
        drive(1'b1, 3'd0, 8'h04, 1'b1, 1'b0, 1'b0);
        peek(3'd0, v); check("R8 write beats flag set", 16'(v), 16'h0004);
        peek16(3'd1, v16); check("R8 count still reloaded", v16, 16'h0102);
        wr(3'd1, 8'hFF); wr(3'd2, 8'h00);
        pulse(1'b1, 1'b0, 1'b0);
        repeat (3) @(negedge clk);
        #1 peek(3'd0, v); check("R8 flag persists", 16'(v), 16'h0044);

        // R9: interrupt combinations
        irq_en = 1'b1;
        wr(3'd0, 8'h40); #1 check("R9 low flag without enable", 16'(irq), 16'h0000);
        wr(3'd0, 8'h60); #1 check("R9 low flag with enable", 16'(irq), 16'h0001);
        wr(3'd0, 8'h80); #1 check("R9 high flag", 16'(irq), 16'h0001);
        irq_en = 1'b0; #1 check("R9 gated by irq_en", 16'(irq), 16'h0000);

        // R10: writes beat same-cycle events
        wr(3'd0, 8'h04);
        drive(1'b1, 3'd1, 8'h77, 1'b1, 1'b0, 1'b0);
        peek(3'd1, v); check("R10 count write beats tick", 16'(v), 16'h0077);
        wr(3'd0, 8'h10); wr(3'd2, 8'h5A);
        drive(1'b1, 3'd3, 8'h99, 1'b0, 1'b0, 1'b1);
        peek16(3'd3, v16); check("R10 reload write beats capture", v16, 16'h5A99);

        // Seeded random run against the model
        for (int i = 0; i < 20000; i++) begin
            @(negedge clk); #1;
            bus_wr     = ($urandom_range(0, 15) == 0);
            bus_addr   = 3'($urandom_range(0, 7));
            bus_wdata  = 8'($urandom);
            tick_sys12 = ($urandom_range(0, 2) == 0);
            tick_ext8  = ($urandom_range(0, 3) == 0);
            tick_rtc8  = ($urandom_range(0, 4) == 0);
            irq_en     = ($urandom_range(0, 1) == 1);
        end
        @(negedge clk); #1;
        bus_wr = 1'b0; tick_sys12 = 1'b0; tick_ext8 = 1'b0; tick_rtc8 = 1'b0;
        @(negedge clk);
        finish_run();
    end
endmodule